// File: doc/BRIEF.md
# Cascaded CAM Active-Address Output Controller

This block sits on the output side of one device in a daisy-chained group of content-addressable memory devices that share a single active-address bus. On every cycle that affects an address, it works out two things. The first is which address source is now current: a match result, the next free slot, a random read, a random write, or an all-ones "nothing found" value. The second is whether this device has the right to drive the shared bus at all. The answer depends on the cycle kind, whether a random access was broadcast, the chip select, the local and upstream match flags, the local and upstream full flags, and a configuration bit that marks the last device in the chain.

The bus value may only move while the cycle enable is high. The value and the ownership are captured when the cycle enable falls. That edge is sampled on the system clock, and the registers update on the clock edge where the fall is seen. Cycles that do not affect an address leave both the value and the ownership untouched. The active-low output enable acts combinationally on the final drive-enable: high forces the bus off, and low lets a device drive only if it is the current owner. A separate drive-enable output feeds an external tri-state wrapper.

Top module: `casc_abus_ctrl`

## Requirements
- R1: After reset, and until the first cycle-enable fall, the device is not the owner: `drv_en_o` is 0 even with `oe_n_i` low, and `addr_o` is 0.
- R2: For a random read (kind 1) or random write (kind 2) with `bcast_i` = 0, the device becomes owner exactly when `sel_i` = 1, and the captured address is `acc_addr_i`.
- R3: For a random read or write with `bcast_i` = 1, the device becomes owner whatever `sel_i` is, and the captured address is `acc_addr_i`.
- R4: For a compare (kind 3) or a highest-priority access (kind 4), the device becomes owner with `match_addr_i` when `match_loc_i` = 1 and `match_up_i` = 0. It is not owner when `match_up_i` = 1.
- R5: For kind 3 or 4 with `match_loc_i` = 0 and `match_up_i` = 0, the device becomes owner with an all-ones address when `last_dev_i` = 1. In every other no-local-match case it is not owner.
- R6: For a write at next free (kind 5), the device becomes owner with `free_addr_i` when `full_up_i` = 1 and `full_loc_i` = 0, whatever `last_dev_i` is. It is not owner when `full_up_i` = 0.
- R7: For kind 5 with `full_up_i` = 1 and `full_loc_i` = 1 (the whole chain is full), the device becomes owner with all ones when `last_dev_i` = 1, and is not owner otherwise.
- R8: Kinds 0, 6 and 7 do not affect an address. A cycle of such a kind leaves ownership and the held address unchanged.
- R9: State changes only on the clock edge where `cyc_en_i` is seen falling (1 in the previous sample, 0 now). While `cyc_en_i` is high during an address-affecting kind, `addr_o` shows the candidate address. Otherwise `addr_o` shows the held address and ignores changes to the address inputs.
- R10: `drv_en_o` = owner AND NOT `oe_n_i`, combinationally. With `oe_n_i` = 1 it is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en_i | input | 1 | Cycle enable; the bus value is captured on its fall |
| kind_i | input | 3 | Cycle kind: 0 idle, 1 read, 2 write, 3 compare, 4 highest-priority access, 5 write at next free, 6/7 non-address |
| bcast_i | input | 1 | Random access is broadcast to all devices |
| sel_i | input | 1 | This device is selected for a random access |
| match_loc_i | input | 1 | This device holds a match |
| match_up_i | input | 1 | Some higher-priority device holds a match |
| full_loc_i | input | 1 | This device is full |
| full_up_i | input | 1 | All higher-priority devices are full |
| last_dev_i | input | 1 | Configuration: this is the lowest-priority device |
| acc_addr_i | input | ADDR_W | Random access address |
| match_addr_i | input | ADDR_W | Local highest-priority match address |
| free_addr_i | input | ADDR_W | Local next free address |
| oe_n_i | input | 1 | Active-low output enable |
| addr_o | output | ADDR_W | Active address value |
| drv_en_o | output | 1 | Drive enable for the tri-state bus wrapper |

## Verification
The bench builds the block with `ADDR_W` = 8. With that width the match, free, access and all-ones values (0x5A, 0x21, 0x3C, 0xFF) are all distinct and easy to tell apart. An address that comes from the wrong source, or a truncated all-ones value, therefore shows up directly at `addr_o`. The narrow width also lets the vector table cover every ownership branch of the cascade flags (upstream match, chain full, last device) in a few hundred cycles. Directed sequences then exercise the held-versus-transparent window of the cycle enable.

// File: rtl/casc_abus_pkg.sv
package casc_abus_pkg;

    typedef enum logic [2:0] {
        CK_IDLE  = 3'd0,
        CK_READ  = 3'd1,
        CK_WRITE = 3'd2,
        CK_CMP   = 3'd3,
        CK_HPRI  = 3'd4,
        CK_WNF   = 3'd5
    } cyc_kind_e;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_MATCH = 3'd1,
        SRC_FREE  = 3'd2,
        SRC_READ  = 3'd3,
        SRC_WRITE = 3'd4,
        SRC_ONES  = 3'd5
    } addr_src_e;

    typedef struct packed {
        logic match_loc;
        logic match_up;
        logic full_loc;
        logic full_up;
        logic last_dev;
    } casc_flags_t;

    function automatic logic kind_is_addr(input logic [2:0] k);
        return (k >= 3'd1) && (k <= 3'd5);
    endfunction

    function automatic logic kind_is_rand(input logic [2:0] k);
        return (k == 3'd1) || (k == 3'd2);
    endfunction

    function automatic logic kind_is_search(input logic [2:0] k);
        return (k == 3'd3) || (k == 3'd4);
    endfunction

endpackage

// File: rtl/casc_fall_det.sv
module casc_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic cyc_en_i,
    output logic fall_o
);
    logic cyc_q;

    always_ff @(posedge clk) begin
        if (rst) cyc_q <= 1'b0;
        else     cyc_q <= cyc_en_i;
    end

    assign fall_o = cyc_q & ~cyc_en_i;
endmodule

// File: rtl/casc_src_sel.sv
module casc_src_sel
    import casc_abus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [2:0]        kind_i,
    input  logic              bcast_i,
    input  logic              sel_i,
    input  casc_flags_t       flags_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [ADDR_W-1:0] match_addr_i,
    input  logic [ADDR_W-1:0] free_addr_i,
    output logic              affect_o,
    output logic              own_o,
    output logic [ADDR_W-1:0] addr_o,
    output addr_src_e         src_o
);
    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

    logic no_match_any;
    logic chain_full;
    logic write_here;

    assign no_match_any = ~flags_i.match_loc & ~flags_i.match_up;
    assign chain_full   = flags_i.full_loc & flags_i.full_up;
    assign write_here   = flags_i.full_up & ~flags_i.full_loc;

    always_comb begin
        affect_o = kind_is_addr(kind_i);
        own_o    = 1'b0;
        addr_o   = '0;
        src_o    = SRC_NONE;
        unique case (cyc_kind_e'(kind_i))
            CK_READ, CK_WRITE: begin
                own_o  = bcast_i | sel_i;
                addr_o = acc_addr_i;
                src_o  = (kind_i == CK_READ) ? SRC_READ : SRC_WRITE;
            end
            CK_CMP, CK_HPRI: begin
                if (flags_i.match_loc) begin
                    own_o  = ~flags_i.match_up;
                    addr_o = match_addr_i;
                    src_o  = SRC_MATCH;
                end else begin
                    own_o  = no_match_any & flags_i.last_dev;
                    addr_o = ALL_ONES;
                    src_o  = SRC_ONES;
                end
            end
            CK_WNF: begin
                if (chain_full) begin
                    own_o  = flags_i.last_dev;
                    addr_o = ALL_ONES;
                    src_o  = SRC_ONES;
                end else begin
                    own_o  = write_here;
                    addr_o = free_addr_i;
                    src_o  = SRC_FREE;
                end
            end
            default: begin
                own_o  = 1'b0;
                addr_o = '0;
                src_o  = SRC_NONE;
            end
        endcase
    end
endmodule

// File: rtl/casc_out_hold.sv
module casc_out_hold
    import casc_abus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_i,
    input  logic              own_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  addr_src_e         src_i,
    output logic              owner_o,
    output logic [ADDR_W-1:0] addr_o,
    output addr_src_e         src_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            owner_o <= 1'b0;
            addr_o  <= '0;
            src_o   <= SRC_NONE;
        end else if (cap_i) begin
            owner_o <= own_i;
            addr_o  <= addr_i;
            src_o   <= src_i;
        end
    end

    // R9: no capture strobe, no state change
    p_nocap_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> ($stable(owner_o) && $stable(addr_o) && $stable(src_o)));
endmodule

// File: rtl/casc_abus_ctrl.sv
module casc_abus_ctrl
    import casc_abus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_en_i,
    input  logic [2:0]        kind_i,
    input  logic              bcast_i,
    input  logic              sel_i,
    input  logic              match_loc_i,
    input  logic              match_up_i,
    input  logic              full_loc_i,
    input  logic              full_up_i,
    input  logic              last_dev_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [ADDR_W-1:0] match_addr_i,
    input  logic [ADDR_W-1:0] free_addr_i,
    input  logic              oe_n_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              drv_en_o
);
    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

    casc_flags_t       flags;
    logic              fall;
    logic              affect;
    logic              own_n;
    logic [ADDR_W-1:0] addr_n;
    addr_src_e         src_n;
    logic              owner_q;
    logic [ADDR_W-1:0] addr_q;
    addr_src_e         src_q;
    logic              capture;

    assign flags = '{match_loc: match_loc_i, match_up: match_up_i,
                     full_loc:  full_loc_i,  full_up:  full_up_i,
                     last_dev:  last_dev_i};

    casc_fall_det u_fall (
        .clk      (clk),
        .rst      (rst),
        .cyc_en_i (cyc_en_i),
        .fall_o   (fall)
    );

    casc_src_sel #(.ADDR_W(ADDR_W)) u_sel (
        .kind_i       (kind_i),
        .bcast_i      (bcast_i),
        .sel_i        (sel_i),
        .flags_i      (flags),
        .acc_addr_i   (acc_addr_i),
        .match_addr_i (match_addr_i),
        .free_addr_i  (free_addr_i),
        .affect_o     (affect),
        .own_o        (own_n),
        .addr_o       (addr_n),
        .src_o        (src_n)
    );

    assign capture = fall & affect;

    casc_out_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .cap_i   (capture),
        .own_i   (own_n),
        .addr_i  (addr_n),
        .src_i   (src_n),
        .owner_o (owner_q),
        .addr_o  (addr_q),
        .src_o   (src_q)
    );

    assign addr_o   = (cyc_en_i && affect) ? addr_n : addr_q;
    assign drv_en_o = owner_q & ~oe_n_i;

    // R1: reset leaves the device without bus ownership
    p_reset_owner_r1: assert property (@(posedge clk)
        rst |=> !owner_q);

    // R2: non-broadcast random access owned only by the selected device
    p_nb_select_r2: assert property (@(posedge clk) disable iff (rst)
        (fall && kind_is_rand(kind_i) && !bcast_i)
        |=> (owner_q == $past(sel_i)) && (addr_q == $past(acc_addr_i)));

    // R3: broadcast random access makes every device an owner
    p_bcast_own_r3: assert property (@(posedge clk) disable iff (rst)
        (fall && kind_is_rand(kind_i) && bcast_i) |=> owner_q);

    // R4: an upstream match always takes priority
    p_upstream_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (fall && kind_is_search(kind_i) && match_up_i) |=> !owner_q);

    // R7: full chain, last device drives all ones
    p_full_ones_r7: assert property (@(posedge clk) disable iff (rst)
        (fall && kind_i == 3'd5 && full_up_i && full_loc_i && last_dev_i)
        |=> (owner_q && addr_q == ALL_ONES));

    // R8: non-address cycles keep ownership and value
    p_nonaddr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (fall && !kind_is_addr(kind_i))
        |=> ($stable(owner_q) && $stable(addr_q)));

    // R8: an owner always has a known address source
    p_owner_src_r8: assert property (@(posedge clk) disable iff (rst)
        owner_q |-> (src_q != SRC_NONE));

    // R10: output enable high always releases the bus
    p_oe_release_r10: assert property (@(posedge clk) disable iff (rst)
        oe_n_i |-> !drv_en_o);
endmodule

// File: tb/casc_abus_ctrl_tb.sv
module casc_abus_ctrl_tb;
    localparam int AW = 8;
    localparam logic [AW-1:0] ACC = 8'h3C;
    localparam logic [AW-1:0] MAT = 8'h5A;
    localparam logic [AW-1:0] FRE = 8'h21;
    localparam logic [AW-1:0] ONES = 8'hFF;

    typedef struct packed {
        logic [2:0] kind;
        logic bc, sel, mloc, mup, floc, fup, last;
        logic own;
        logic [7:0] addr;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    // fields: kind bc sel mloc mup floc fup last | own addr req
    localparam vec_t VEC [NV] = '{
        '{3'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h3C,4'd2}, // R2 read selected
        '{3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00,4'd2}, // R2 read other chip
        '{3'd2,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h3C,4'd2}, // R2 write selected
        '{3'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00,4'd2}, // R2 write other chip
        '{3'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h3C,4'd3}, // R3 broadcast write
        '{3'd3,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h5A,4'd4}, // R4 local top match
        '{3'd3,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 1'b0,8'h00,4'd4}, // R4 upstream wins
        '{3'd4,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h5A,4'd4}, // R4 hp access
        '{3'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,8'hFF,4'd5}, // R5 no match, last
        '{3'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00,4'd5}, // R5 no match, not last
        '{3'd4,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 1'b0,8'h00,4'd5}, // R5 last but upstream match
        '{3'd5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,8'h21,4'd6}, // R6 written here
        '{3'd5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00,4'd6}, // R6 upstream has room
        '{3'd5,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1,8'hFF,4'd7}, // R7 chain full, last
        '{3'd5,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b0,8'h00,4'd7}, // R7 chain full, not last
        '{3'd5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1,8'h21,4'd6}  // R6 last bit irrelevant
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_en = 1'b0;
    logic [2:0] kind = 3'd0;
    logic bcast = 1'b0, sel = 1'b0, mloc = 1'b0, mup = 1'b0;
    logic floc = 1'b0, fup = 1'b0, last = 1'b0;
    logic [AW-1:0] acc = ACC, mat = MAT, fre = FRE;
    logic oe_n = 1'b1;
    logic [AW-1:0] addr;
    logic drv_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    casc_abus_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .cyc_en_i(cyc_en), .kind_i(kind),
        .bcast_i(bcast), .sel_i(sel), .match_loc_i(mloc), .match_up_i(mup),
        .full_loc_i(floc), .full_up_i(fup), .last_dev_i(last),
        .acc_addr_i(acc), .match_addr_i(mat), .free_addr_i(fre),
        .oe_n_i(oe_n), .addr_o(addr), .drv_en_o(drv_en)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic set_in(input vec_t v);
        kind = v.kind; bcast = v.bc; sel = v.sel; mloc = v.mloc; mup = v.mup;
        floc = v.floc; fup = v.fup; last = v.last;
    endtask

    // raise cycle enable at a negedge, drop it at the next, and return
    // one negedge later (state captured on the posedge in between)
    task automatic pulse_cycle();
        cyc_en = 1'b1;
        @(negedge clk);
        cyc_en = 1'b0;
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got 0x%0h expected 0x%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        oe_n = 1'b0;
        #1;
        // R1 reset state
        check(drv_en == 1'b0, "R1 drive after reset", int'(drv_en), 0);
        check(addr == '0, "R1 address after reset", int'(addr), 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            oe_n = 1'b0;
            set_in(VEC[i]);
            pulse_cycle();
            check(drv_en == VEC[i].own, $sformatf("R%0d drive vec %0d", VEC[i].req, i),
                  int'(drv_en), int'(VEC[i].own));
            if (VEC[i].own)
                check(addr == VEC[i].addr, $sformatf("R%0d addr vec %0d", VEC[i].req, i),
                      int'(addr), int'(VEC[i].addr));
            oe_n = 1'b1;
            #1;
            // R10 output enable high releases the bus
            check(drv_en == 1'b0, $sformatf("R10 oe high vec %0d", i), int'(drv_en), 0);
        end

        // R8: non-address kinds hold ownership and value
        @(negedge clk);
        oe_n = 1'b0;
        set_in(VEC[5]);               // own with match address
        pulse_cycle();
        for (int k = 0; k < 3; k++) begin
            logic [2:0] nk;
            nk = (k == 0) ? 3'd0 : ((k == 1) ? 3'd6 : 3'd7);
            @(negedge clk);
            kind = nk; mloc = 1'b0; mup = 1'b1; sel = 1'b0;
            pulse_cycle();
            check(drv_en == 1'b1, $sformatf("R8 hold owner kind %0d", nk), int'(drv_en), 1);
            check(addr == MAT, $sformatf("R8 hold addr kind %0d", nk), int'(addr), int'(MAT));
        end

        // R9: no cycle-enable fall, no capture
        @(negedge clk);
        kind = 3'd3; mloc = 1'b0; mup = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        check(drv_en == 1'b1, "R9 no fall keeps owner", int'(drv_en), 1);
        check(addr == MAT, "R9 no fall keeps addr", int'(addr), int'(MAT));

        // R9: transparent while enable high on address cycle
        @(negedge clk);
        kind = 3'd5; fup = 1'b1; floc = 1'b0; last = 1'b0;
        cyc_en = 1'b1;
        #1;
        check(addr == FRE, "R9 transparent while high", int'(addr), int'(FRE));
        check(drv_en == 1'b1, "R9 ownership unchanged while high", int'(drv_en), 1);
        @(negedge clk);
        cyc_en = 1'b0;
        @(negedge clk);
        #1;
        fre = 8'h77;
        #1;
        check(addr == FRE, "R9 held while low", int'(addr), int'(FRE));
        // R9: enable high with a non-address kind shows the held value
        kind = 3'd0;
        cyc_en = 1'b1;
        #1;
        check(addr == FRE, "R9 held on idle high", int'(addr), int'(FRE));
        @(negedge clk);
        cyc_en = 1'b0;
        @(negedge clk);
        fre = FRE;

        // R1: reset mid-operation drops ownership
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(drv_en == 1'b0, "R1 reset drops owner", int'(drv_en), 0);
        check(addr == '0, "R1 reset clears addr", int'(addr), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule